// File: doc/BRIEF.md
# Fractional Baud Rate Generator

This block derives the bit-timing ticks of a serial interface from the module clock. It has two dividing stages in series. The first is a phase-accumulating prescaler. On every clock it adds a 9-bit numerator to a 9-bit phase. It passes one clock enable for each wrap of that phase, so it keeps a fraction numerator/512 of the clock edges. A numerator of zero switches the prescaler off, and every clock edge then passes through.

The second stage is a 13-bit reload down-counter that runs on the thinned enable stream. Each time it underflows it emits one tick and divides by the reload value plus one. The mode select decides which output carries the ticks. In asynchronous mode they drive a 16x oversampling strobe, so the baud rate is the tick rate over 16. In synchronous mode they drive a clock strobe that runs at four times the bit rate.

A low enable stops and clears both stages. A new reload value is picked up at the next underflow. A new numerator acts from the next clock edge. With a module clock of 36 MHz, a numerator of 367 and a reload value of 6 give 230.4 kBaud. A reload value of 13 with the same numerator gives 115.2 kBaud.

Top module: `fbrg_baud_gen`

## Requirements
- R1: While reset (rst_n low) is applied, and on the first cycle after it, both tick outputs are low.
- R2: With frac_i equal to 0, the prescaler is bypassed and every clock edge is an enable. With reload_i equal to 0, a tick is then produced on every clock.
- R3: With frac_i = F, not 0, and k counted as the clock edges since en_i rose, edge k is an enable exactly when floor(k*F/512) is greater than floor((k-1)*F/512).
- R4: The first enable after en_i rises produces a tick. After that, a tick comes on every (reload_i + 1)-th enable.
- R5: A tick shows on its output for exactly one cycle, starting right after the clock edge that consumed the underflowing enable.
- R6: With sync_mode_i = 0 (asynchronous), ticks appear on tick16_o and clk4_o stays low.
- R7: With sync_mode_i = 1 (synchronous), ticks appear on clk4_o and tick16_o stays low.
- R8: While en_i is low, neither output pulses. Both stages restart from zero, so the first enable after re-enabling gives a tick at once.
- R9: A change of reload_i does not shorten or lengthen the period already in progress. It sets the length of the period that starts at the next tick. A change of frac_i applies from the next clock edge.
- R10: The extremes divide exactly: frac_i = 1 keeps one edge in 512, and reload_i = 8191 makes the counter divide by 8192.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_i | input | 1 | Run enable; low clears both stages |
| sync_mode_i | input | 1 | 0 = asynchronous (16x strobe), 1 = synchronous (4x clock strobe) |
| reload_i | input | 13 | Reload value of the down-counter, 0 to 8191 |
| frac_i | input | 9 | Prescaler numerator over 512; 0 bypasses the prescaler |
| tick16_o | output | 1 | One-cycle 16x oversampling strobe (asynchronous mode) |
| clk4_o | output | 1 | One-cycle 4x bit-rate clock strobe (synchronous mode) |

## Verification
Each tick is due on the cycle right after the edge that consumes the underflowing enable. The prescaler decision and the counter compare are both combinational in the edge that consumes the enable, and only the output stage is a register. The driver sets the inputs at a falling edge and works out, from the running numerator sum and the enable count, whether the next rising edge yields a tick. If it does, it queues the cycle number that edge will produce together with the mode, and the monitor compares the outputs at every falling edge against the queue head. A reload change is modelled at the edge where the model's own period ends, so the old period finishing and the new one starting are both checked cycle-exactly.

// File: rtl/fbrg_pkg.sv
package fbrg_pkg;
  localparam int DEF_RLD_W  = 13;
  localparam int DEF_FRAC_W = 9;

  typedef enum logic {
    MODE_ASYNC = 1'b0,
    MODE_SYNC  = 1'b1
  } bmode_t;
endpackage

// File: rtl/fbrg_frac_pre.sv
module fbrg_frac_pre #(
  parameter int FRAC_W = fbrg_pkg::DEF_FRAC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic [FRAC_W-1:0] frac_i,
  output logic              fen_o,
  output logic [FRAC_W-1:0] acc_o
);
  localparam logic [FRAC_W-1:0] ZERO = '0;

  // phase step: returns {carry, new phase}
  function automatic logic [FRAC_W:0] phase_add(input logic [FRAC_W-1:0] ph,
                                                input logic [FRAC_W-1:0] num);
    return {1'b0, ph} + {1'b0, num};
  endfunction

  logic [FRAC_W-1:0] acc_q;
  logic [FRAC_W:0]   step;
  logic              bypass;
  logic              wrap;

  always_comb begin
    step   = phase_add(acc_q, frac_i);
    bypass = (frac_i == ZERO);
    wrap   = step[FRAC_W];
    fen_o  = run_i & (bypass | wrap);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       acc_q <= ZERO;
    else if (!run_i)  acc_q <= ZERO;
    else if (!bypass) acc_q <= step[FRAC_W-1:0];
  end

  assign acc_o = acc_q;

  AST_PHASE_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && frac_i != ZERO) |=> acc_o == $past(acc_o) + $past(frac_i)); // R3
  AST_BYPASS_HOLDS_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && frac_i == ZERO) |=> $stable(acc_o)); // R2
  AST_PHASE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> acc_o == ZERO); // R8
endmodule

// File: rtl/fbrg_reload_div.sv
module fbrg_reload_div #(
  parameter int RLD_W = fbrg_pkg::DEF_RLD_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             fen_i,
  input  logic [RLD_W-1:0] reload_i,
  output logic             uflow_o,
  output logic [RLD_W-1:0] cnt_o
);
  localparam logic [RLD_W-1:0] ZERO = '0;
  localparam logic [RLD_W-1:0] ONE  = {{(RLD_W-1){1'b0}}, 1'b1};

  function automatic logic [RLD_W-1:0] count_step(input logic [RLD_W-1:0] cur,
                                                  input logic [RLD_W-1:0] rld,
                                                  input logic             adv);
    if (!adv)           return cur;
    else if (cur == ZERO) return rld;
    else                return cur - ONE;
  endfunction

  logic [RLD_W-1:0] cnt_q;

  assign uflow_o = fen_i & (cnt_q == ZERO);
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= ZERO;
    else if (!run_i) cnt_q <= ZERO;
    else             cnt_q <= count_step(cnt_q, reload_i, fen_i);
  end

  AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && fen_i && cnt_o != ZERO) |=> cnt_o == $past(cnt_o) - ONE); // R4
  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !fen_i) |=> $stable(cnt_o)); // R4
  AST_RELOAD_AT_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && uflow_o) |=> cnt_o == $past(reload_i)); // R9
  AST_COUNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> cnt_o == ZERO); // R8
endmodule

// File: rtl/fbrg_tick_out.sv
module fbrg_tick_out
  import fbrg_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   run_i,
  input  bmode_t mode_i,
  input  logic   uflow_i,
  output logic   tick16_o,
  output logic   clk4_o
);
  logic t16_q, c4_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      t16_q <= 1'b0;
      c4_q  <= 1'b0;
    end else begin
      t16_q <= run_i & uflow_i & (mode_i == MODE_ASYNC);
      c4_q  <= run_i & uflow_i & (mode_i == MODE_SYNC);
    end
  end

  assign tick16_o = t16_q;
  assign clk4_o   = c4_q;

  AST_SINGLE_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tick16_o, clk4_o})); // R6
  AST_ASYNC_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && uflow_i && mode_i == MODE_ASYNC) |=> tick16_o); // R5
  AST_SYNC_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && uflow_i && mode_i == MODE_SYNC) |=> clk4_o); // R7
  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (!tick16_o && !clk4_o)); // R8
endmodule

// File: rtl/fbrg_baud_gen.sv
module fbrg_baud_gen
  import fbrg_pkg::*;
#(
  parameter int RLD_W  = DEF_RLD_W,
  parameter int FRAC_W = DEF_FRAC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              sync_mode_i,
  input  logic [RLD_W-1:0]  reload_i,
  input  logic [FRAC_W-1:0] frac_i,
  output logic              tick16_o,
  output logic              clk4_o
);
  // named internal events
  logic              frac_en;
  logic              cnt_uflow;
  logic [FRAC_W-1:0] phase;
  logic [RLD_W-1:0]  count;
  bmode_t            mode;

  assign mode = bmode_t'(sync_mode_i);

  fbrg_frac_pre #(.FRAC_W(FRAC_W)) u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (en_i),
    .frac_i (frac_i),
    .fen_o  (frac_en),
    .acc_o  (phase)
  );

  fbrg_reload_div #(.RLD_W(RLD_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_i    (en_i),
    .fen_i    (frac_en),
    .reload_i (reload_i),
    .uflow_o  (cnt_uflow),
    .cnt_o    (count)
  );

  fbrg_tick_out u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_i    (en_i),
    .mode_i   (mode),
    .uflow_i  (cnt_uflow),
    .tick16_o (tick16_o),
    .clk4_o   (clk4_o)
  );

  AST_TICK_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick16_o || clk4_o) |-> $past(frac_en)); // R4
  AST_RESTART_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (phase == '0 && count == '0)); // R8
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> (!tick16_o && !clk4_o)); // R1
endmodule

// File: tb/sim_fbrg_baud_gen.sv
module sim_fbrg_baud_gen;
  localparam int CLK_PERIOD = 10;
  localparam int RW         = 13;
  localparam int FW         = 9;
  localparam int MODULUS    = 1 << FW;
  localparam int WATCHDOG   = 150000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en = 1'b0;
  logic          sync_m = 1'b0;
  logic [RW-1:0] rld = '0;
  logic [FW-1:0] frac = '0;
  logic          tick16, clk4;

  fbrg_baud_gen u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .en_i        (en),
    .sync_mode_i (sync_m),
    .reload_i    (rld),
    .frac_i      (frac),
    .tick16_o    (tick16),
    .clk4_o      (clk4)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int due;
    bit is_sync;
    int req;
  } exp_t;
  exp_t q[$];

  int    tests = 0;
  int    fails = 0;
  bit    done  = 1'b0;
  longint m_sum = 0;
  int    m_j = 0;
  int    m_next = 1;

  function automatic string rname(input int r);
    case (r)
      1: return "R1";   2: return "R2";   3: return "R3";
      4: return "R4";   5: return "R5";   6: return "R6";
      7: return "R7";   8: return "R8";   9: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s cycle %0d: actual=%0d expected=%0d", req, cyc, act, expv);
    end
  endtask

  // reference: running numerator sum and enable index, set by the requirements
  task automatic model_step(input int req);
    bit fen;
    if (!en) begin
      m_sum = 0; m_j = 0; m_next = 1;
    end else begin
      if (frac == 0) fen = 1'b1;                          // R2
      else begin
        fen = ((m_sum + frac) / MODULUS) != (m_sum / MODULUS); // R3
        m_sum += frac;
      end
      if (fen) begin
        m_j++;
        if (m_j == m_next) begin                          // R4 / R9
          q.push_back(exp_t'{due: cyc + 1, is_sync: sync_m, req: req}); // R5
          m_next = m_j + int'(rld) + 1;
        end
      end
    end
  endtask

  task automatic drive(input bit e, input bit s, input int r, input int f,
                       input int n, input int req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      en = e; sync_m = s; rld = RW'(r); frac = FW'(f);
      model_step(req);
    end
  endtask

  // monitor: pops the scoreboard and compares outputs
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (q.size() > 0 && q[0].due == cyc) begin
        exp_t e;
        e = q.pop_front();
        tests++;
        if (tick16 != !e.is_sync || clk4 != e.is_sync) begin
          fails++;
          $display("FAIL %s cycle %0d: tick16=%0b clk4=%0b expected tick16=%0b clk4=%0b",
                   rname(e.req), cyc, tick16, clk4, !e.is_sync, e.is_sync);
        end
      end else if (tick16 || clk4) begin
        tests++;
        fails++;
        $display("FAIL R4 cycle %0d: unexpected tick16=%0b clk4=%0b expected tick16=0 clk4=0",
                 cyc, tick16, clk4);
      end
    end
  end

  always @(posedge clk) begin
    if (cyc >= WATCHDOG && !done) begin
      done = 1'b1;
      tests++;
      fails++;
      $display("FAIL R4 watchdog: actual cycle=%0d expected below %0d", cyc, WATCHDOG);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    check(tick16 == 1'b0 && clk4 == 1'b0, "R1", {tick16, clk4}, 0);   // R1 during reset
    @(negedge clk);
    rst_n = 1'b1;
    model_step(1);
    @(negedge clk);
    check(tick16 == 1'b0 && clk4 == 1'b0, "R1", {tick16, clk4}, 0);   // R1 after reset

    drive(1, 0, 0, 0, 20, 2);        // R2 bypass, tick every clock, R6 async
    drive(0, 0, 0, 0, 3, 8);
    drive(1, 0, 4, 0, 30, 4);        // R4 divide by five
    drive(0, 0, 4, 0, 3, 8);
    drive(1, 1, 2, 0, 20, 7);        // R7 synchronous strobe
    drive(0, 1, 2, 0, 3, 8);
    drive(1, 0, 6, 367, 200, 3);     // R3 230.4 kBaud setting
    drive(1, 1, 13, 367, 200, 7);    // R7 mode switch mid-run
    drive(0, 0, 0, 0, 3, 8);
    drive(1, 1, 1, 100, 150, 3);     // R3 other numerator

    // R8: disable mid-period, nothing may pulse, restart ticks at once
    drive(1, 0, 9, 0, 4, 8);
    drive(0, 0, 9, 0, 12, 8);
    check(q.size() == 0, "R8", q.size(), 0);
    drive(1, 0, 9, 0, 25, 8);

    // R9: reload change mid-period, numerator change mid-run
    drive(0, 0, 5, 0, 2, 9);
    drive(1, 0, 5, 0, 3, 9);
    drive(1, 0, 1, 0, 20, 9);
    drive(1, 0, 2, 200, 40, 9);
    drive(1, 0, 2, 50, 80, 9);
    drive(0, 0, 0, 0, 3, 8);

    // R10: extremes
    drive(1, 0, 0, 1, 1600, 10);
    drive(0, 0, 0, 0, 3, 8);
    drive(1, 0, 8191, 0, 8200, 10);
    drive(0, 0, 0, 0, 3, 8);

    @(negedge clk);
    @(negedge clk);
    check(q.size() == 0, "R4", q.size(), 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule